// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sits on a simple register bus and holds one byte-wide mode register. The two lowest bits of that register choose how the chip runs. It can run normally. It can stop only the processor clock. It can stop every clock while an embedded DRAM keeps its contents through self-refresh. The block drives a processor clock enable, a global clock enable and a self-refresh request. Clock generation and the refresh engine are outside it.

Wake events come in on three asynchronous pins: an external interrupt, a system-break interrupt and a wakeup pin. Each pin passes through a two-flop synchronizer clocked by the always-on clock. When a wake event ends a low-power period, the mode register keeps its code, so software can read it to learn which mode was left. The block stays locked against a new entry until software writes 00. After that, a write of 10 or 11 arms a new entry.

The register port is a plain write strobe with data, plus a read-data bus that always shows the register. It has no handshake: a write is taken in the cycle its strobe is high, or, in a low-power state, dropped.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, rd_data is 0x00, cpu_clk_en and sys_clk_en are 1 and sr_req is 0.
- R2: A write in normal operation stores wr_data[1:0] into register bits [1:0]. rd_data[7:2] always reads 0.
- R3: When the interlock is open, a write with code 10 (bits [1:0]) makes cpu_clk_en 0 from the cycle after the write. sys_clk_en stays 1 and sr_req stays 0.
- R4: In CPU sleep, ext_irq or brk_irq raises cpu_clk_en again after the third rising clock edge following the pin's rise, counting two sync stages and one state update. Reset also ends CPU sleep.
- R5: When the interlock is open, a write with code 11 makes cpu_clk_en and sys_clk_en 0 and sr_req 1 from the cycle after the write.
- R6: In standby, ext_irq and brk_irq have no effect. wake_pin drops sr_req after the third edge, and both clock enables return one cycle later.
- R7: After a wake by a pin, rd_data still shows the code that caused the entry.
- R8: After any pin wake, writes of 10 or 11 are stored but cause no clock gating until a write of 00 has been taken.
- R9: Code 01 is stored and read back but gates no clock and does not reopen the interlock.
- R10: Writes that arrive while in CPU sleep or standby are dropped, and the register keeps its value.
- R11: Reset during CPU sleep or standby returns to normal operation, clears the register and opens the interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register contents |
| ext_irq | input | 1 | External interrupt, asynchronous |
| brk_irq | input | 1 | System-break interrupt, asynchronous |
| wake_pin | input | 1 | Standby wakeup, asynchronous |
| cpu_clk_en | output | 1 | Processor clock enable |
| sys_clk_en | output | 1 | Global clock enable |
| sr_req | output | 1 | DRAM self-refresh request |

## Verification
The assertions assume that each wake pin stays high for at least three clock cycles, so the synchronized level reaches the state logic. They also assume that writes come only from the bus strobe and never overlap a wake transition. The stimulus holds every wake pulse for six cycles and then leaves the pin low for four cycles before the next operation. Register writes are issued only between wake pulses. Random codes and random wake sources hit every state, including writes while locked, wrong-source wakes in standby and writes dropped during low power.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int REG_W  = 8;
  localparam int MODE_W = 2;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_DOZE   = 2'd1,
    ST_HALT   = 2'd2,
    ST_RESUME = 2'd3
  } lpm_state_e;

  localparam logic [MODE_W-1:0] CODE_RUN  = 2'b00;
  localparam logic [MODE_W-1:0] CODE_RSVD = 2'b01;
  localparam logic [MODE_W-1:0] CODE_DOZE = 2'b10;
  localparam logic [MODE_W-1:0] CODE_HALT = 2'b11;
endpackage

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lpm_regfile.sv
module lpm_regfile
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              accept,
  input  logic              wake_done,
  output logic [MODE_W-1:0] mode,
  output logic              armed,
  output logic              enter_req,
  output logic              enter_stby,
  output logic [REG_W-1:0]  rd_data
);
  logic                 take;
  logic [MODE_W-1:0]    code;
  logic [REG_W-MODE_W-1:0] unused_hi;

  assign take      = wr_en && accept;
  assign code      = wr_data[MODE_W-1:0];
  assign unused_hi = wr_data[REG_W-1:MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= CODE_RUN;
    else if (take) mode <= code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b1;
    else if (wake_done) armed <= 1'b0;
    else if (take && code == CODE_RUN) armed <= 1'b1;
  end

  assign enter_req  = take && armed && code[MODE_W-1];
  assign enter_stby = code[0];
  assign rd_data    = {{(REG_W-MODE_W){1'b0}}, mode};

  // R10: register frozen while a low-power state holds
  a_r10_hold_in_lp: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(mode));
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       enter_stby,
  input  logic       irq_s,
  input  logic       brk_s,
  input  logic       wake_s,
  output lpm_state_e state,
  output logic       wake_done,
  output logic       cpu_clk_en,
  output logic       sys_clk_en,
  output logic       sr_req
);
  lpm_state_e nxt;

  always_comb begin
    nxt       = state;
    wake_done = 1'b0;
    case (state)
      ST_RUN:    if (enter_req) nxt = enter_stby ? ST_HALT : ST_DOZE;
      ST_DOZE:   if (irq_s || brk_s) begin nxt = ST_RUN; wake_done = 1'b1; end
      ST_HALT:   if (wake_s) nxt = ST_RESUME;
      ST_RESUME: begin nxt = ST_RUN; wake_done = 1'b1; end
      default:   nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign cpu_clk_en = (state == ST_RUN);
  assign sys_clk_en = (state == ST_RUN) || (state == ST_DOZE);
  assign sr_req     = (state == ST_HALT);

  // R6: interrupts cannot end standby
  a_r6_halt_deaf: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !wake_s) |=> state == ST_HALT);
  // R6: refresh request released before clocks return
  a_r6_sr_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_clk_en) |-> !$past(sr_req));
  // R4: interrupt ends CPU sleep on the next edge
  a_r4_doze_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DOZE && (irq_s || brk_s)) |=> cpu_clk_en);
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             ext_irq,
  input  logic             brk_irq,
  input  logic             wake_pin,
  output logic             cpu_clk_en,
  output logic             sys_clk_en,
  output logic             sr_req
);
  localparam int N_WAKE = 3;

  logic [N_WAKE-1:0] wake_raw, wake_sync;
  logic [MODE_W-1:0] mode;
  logic              armed, enter_req, enter_stby, wake_done;
  lpm_state_e        state;

  assign wake_raw = {wake_pin, brk_irq, ext_irq};

  lpm_sync #(.WIDTH(N_WAKE), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(wake_raw), .q(wake_sync)
  );

  lpm_regfile u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .accept(state == ST_RUN), .wake_done(wake_done),
    .mode(mode), .armed(armed), .enter_req(enter_req),
    .enter_stby(enter_stby), .rd_data(rd_data)
  );

  lpm_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .enter_req(enter_req), .enter_stby(enter_stby),
    .irq_s(wake_sync[0]), .brk_s(wake_sync[1]), .wake_s(wake_sync[2]),
    .state(state), .wake_done(wake_done),
    .cpu_clk_en(cpu_clk_en), .sys_clk_en(sys_clk_en), .sr_req(sr_req)
  );

  // R8: locked interlock keeps normal operation
  a_r8_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && state == ST_RUN) |=> state == ST_RUN);
  // R3: armed sleep write stops the processor clock next cycle
  a_r3_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && wr_en && armed && wr_data[1]) |=> !cpu_clk_en);
  // R7: code kept across a wake
  a_r7_cause_kept: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> $stable(mode));
endmodule

// File: tb/lpm_ctrl_tb.sv
module lpm_ctrl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       ext_irq = 0, brk_irq = 0, wake_pin = 0;
  logic       cpu_clk_en, sys_clk_en, sr_req;

  int n_chk = 0, n_fail = 0;
  int m_state = 0;   // 0 run, 1 sleep, 2 standby
  logic [1:0] m_mode = 0;
  bit m_armed = 1;

  always #10 clk = ~clk;

  lpm_ctrl u_dut (.*);

  function automatic logic exp_cpu(int s); return s == 0; endfunction
  function automatic logic exp_sys(int s); return s != 2; endfunction
  function automatic logic exp_sr(int s);  return s == 2; endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " cpu_clk_en"}, {7'd0, cpu_clk_en}, {7'd0, exp_cpu(m_state)});
    chk({req, " sys_clk_en"}, {7'd0, sys_clk_en}, {7'd0, exp_sys(m_state)});
    chk({req, " sr_req"},     {7'd0, sr_req},     {7'd0, exp_sr(m_state)});
    chk({req, " rd_data"},    rd_data,            {6'd0, m_mode});
  endtask

  task automatic do_write(logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (m_state == 0) begin
      m_mode = d[1:0];
      if (d[1:0] == 2'b00) m_armed = 1;
      else if (d[1] && m_armed) m_state = d[0] ? 2 : 1;
    end
  endtask

  // src: 0 ext_irq, 1 brk_irq, 2 wake_pin
  task automatic pulse(int src);
    @(negedge clk);
    case (src) 0: ext_irq = 1; 1: brk_irq = 1; default: wake_pin = 1; endcase
    repeat (6) @(negedge clk);
    ext_irq = 0; brk_irq = 0; wake_pin = 0;
    repeat (4) @(negedge clk);
    if ((m_state == 1 && src != 2) || (m_state == 2 && src == 2)) begin
      m_state = 0; m_armed = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    #1 chk_all("R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); chk_all("R1 after reset");

    do_write(8'hFC); chk_all("R2 high bits zero");
    do_write(8'h01); chk_all("R9 reserved no gating");
    do_write(8'h02); chk_all("R9 reserved keeps armed, R3 entry");
    // R4 latency: processor clock returns after third edge
    @(negedge clk); ext_irq = 1;
    @(negedge clk); chk("R4 edge1", {7'd0, cpu_clk_en}, 8'd0);
    @(negedge clk); chk("R4 edge2", {7'd0, cpu_clk_en}, 8'd0);
    @(negedge clk); chk("R4 edge3", {7'd0, cpu_clk_en}, 8'd1);
    ext_irq = 0; repeat (4) @(negedge clk);
    m_state = 0; m_armed = 0;
    chk_all("R7 cause after sleep wake");
    do_write(8'h03); chk_all("R8 locked standby write");
    do_write(8'h01); chk_all("R9 reserved does not unlock");
    do_write(8'h02); chk_all("R8 still locked");
    do_write(8'h00); do_write(8'h03); chk_all("R5 standby entry");
    do_write(8'h00); chk_all("R10 write dropped in standby");
    pulse(0); chk_all("R6 irq ignored in standby");
    pulse(1); chk_all("R6 brk ignored in standby");
    // R6 ordering: refresh drops before clocks
    @(negedge clk); wake_pin = 1;
    repeat (3) @(negedge clk);
    chk("R6 sr dropped", {7'd0, sr_req}, 8'd0);
    chk("R6 clocks still off", {7'd0, sys_clk_en}, 8'd0);
    @(negedge clk);
    chk("R6 clocks back", {6'd0, sys_clk_en, cpu_clk_en}, 8'd3);
    wake_pin = 0; repeat (4) @(negedge clk);
    m_state = 0; m_armed = 0;
    chk_all("R7 cause after standby wake");
    do_write(8'h00); do_write(8'h03);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_state = 0; m_mode = 0; m_armed = 1;
    @(negedge clk); chk_all("R11 reset from standby");
    do_write(8'h02); chk_all("R11 armed after reset");
    pulse(1); chk_all("R4 brk wake");

    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 5) do_write(8'($urandom));
      else pulse($urandom_range(0, 2));
      chk_all("R2 R3 R5 R8 R10 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule